// File: doc/BRIEF.md
# Span Gouraud Shader

This block fills one horizontal run of pixels. A loading sequencer writes start values and per-pixel gradients for red, green, blue and depth, a base x and y, and then a pixel count. From the cycle after the count write, the block emits one pixel per clock. Four accumulators step in parallel, so red, green, blue and depth all advance by their gradients on every pixel. All values are 16.16 fixed point. Only the integer half reaches the pixel port. Colours are clipped to 0..255 there.

A second way of starting the block is tile fill, used for fast clearing. Each unit of the tile count produces a 4 by 2 block of pixels in the constant start colour and depth. The start registers are read but never changed. While the block is busy, `ready` is low and the writer must stall. Writes presented while busy are dropped.

The controller has three states. In IDLE, `ready` is high. A nonzero span count moves it to SPAN. A nonzero tile count moves it to TILE. A zero count leaves it in IDLE. SPAN returns to IDLE after the last pixel of the run. TILE returns to IDLE after the eighth pixel of the last tile.

Top module: `span_shader`

## Requirements
- R1: After reset, `ready` is 1 and `pix_valid` is 0.
- R2: Register select codes are: 0..3 start R, G, B, Z; 4..7 gradient R, G, B, Z; 8 base x; 9 base y; 10 span count (starts a span); 11 tile count (starts a tile fill). Base x, base y and the counts take the low bits of `wr_data` as plain integers.
- R3: A nonzero span count N written while `ready` is 1 gives exactly N consecutive cycles with `pix_valid` high, starting the cycle after the write. `ready` is 1 again in the cycle after the last pixel.
- R4: In a span, pixel i has x = base x + i and y = base y.
- R5: In a span, pixel i uses accumulator value start + i*gradient (32-bit wrap) for each channel. `pix_z` is bits 31:16 of the depth accumulator.
- R6: The colour output is the signed integer part (bits 31:16) of the channel. A negative value gives 0, and a value above 255 gives 255.
- R7: A count of zero, span or tile, produces no pixel and `ready` never drops.
- R8: While `ready` is 0, every write is ignored, including count writes. No register changes and no extra run follows.
- R9: A tile count M gives 8*M pixels. Tile k (0-based) covers x = 4*(base x + k) + c for c = 0..3. It emits row y = base y first and then row base y + 1, with c ascending. Every tile pixel carries the clipped start colours and the start depth.
- R10: Tile fill leaves the start registers unchanged. A following span with no reload begins at the same start values.
- R11: Each span count write restarts the accumulators from the start registers, so two spans in a row with no reload produce identical pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select code (see R2) |
| wr_data | input | 32 | Write data |
| ready | output | 1 | High when idle and able to accept writes |
| pix_valid | output | 1 | Pixel on the port is valid |
| pix_x | output | 16 | Pixel x |
| pix_y | output | 16 | Pixel y |
| pix_r | output | 8 | Clipped red |
| pix_g | output | 8 | Clipped green |
| pix_b | output | 8 | Clipped blue |
| pix_z | output | 16 | Integer depth |

## Verification
The assertions check the following on every cycle:
- a zero count keeps the unit ready;
- span x advances by exactly one between adjacent pixels;
- tile pixels stay on the two rows at base y;
- tile colour and depth hold steady;
- no pixel appears without a preceding write.

The bench scenarios cover the rest:
- the exact accumulated values and clipping;
- the pixel count and its end point;
- dropped writes while busy;
- tile ordering;
- the restart behaviour around tile fill and repeated spans.

// File: rtl/span_pkg.sv
package span_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SPAN,
        ST_TILE
    } sh_state_t;

    localparam int NCH        = 4;
    localparam logic [3:0] SEL_START0 = 4'd0;
    localparam logic [3:0] SEL_GRAD0  = 4'd4;
    localparam logic [3:0] SEL_XBASE  = 4'd8;
    localparam logic [3:0] SEL_YBASE  = 4'd9;
    localparam logic [3:0] SEL_SPAN   = 4'd10;
    localparam logic [3:0] SEL_TILE   = 4'd11;

    function automatic logic [7:0] clip8(input logic signed [15:0] v);
        if (v < 0)
            clip8 = 8'd0;
        else if (v > 16'sd255)
            clip8 = 8'd255;
        else
            clip8 = v[7:0];
    endfunction
endpackage

// File: rtl/span_regs.sv
module span_regs
    import span_pkg::*;
#(
    parameter int DW = 32,
    parameter int XW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [3:0]              wr_sel,
    input  logic [DW-1:0]           wr_data,
    input  logic                    accept,
    output logic [NCH-1:0][DW-1:0]  start_v,
    output logic [NCH-1:0][DW-1:0]  grad_v,
    output logic [XW-1:0]           xbase,
    output logic [XW-1:0]           ybase
);
    logic wr_ok;
    assign wr_ok = wr_en && accept;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                start_v[c] <= '0;
                grad_v[c]  <= '0;
            end else if (wr_ok) begin
                if (wr_sel == SEL_START0 + 4'(c))
                    start_v[c] <= wr_data;
                if (wr_sel == SEL_GRAD0 + 4'(c))
                    grad_v[c] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xbase <= '0;
            ybase <= '0;
        end else if (wr_ok) begin
            if (wr_sel == SEL_XBASE) xbase <= wr_data[XW-1:0];
            if (wr_sel == SEL_YBASE) ybase <= wr_data[XW-1:0];
        end
    end
endmodule

// File: rtl/span_lanes.sv
module span_lanes
    import span_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    step,
    input  logic [NCH-1:0][DW-1:0]  start_v,
    input  logic [NCH-1:0][DW-1:0]  grad_v,
    output logic [NCH-1:0][DW-1:0]  acc
);
    for (genvar c = 0; c < NCH; c++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                acc[c] <= '0;
            else if (load)
                acc[c] <= start_v[c];
            else if (step)
                acc[c] <= acc[c] + grad_v[c];
        end
    end
endmodule

// File: rtl/span_ctrl.sv
module span_ctrl
    import span_pkg::*;
#(
    parameter int CW = 16,
    parameter int XW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_sel,
    input  logic [CW-1:0] wr_count,
    input  logic [XW-1:0] xbase,
    input  logic [XW-1:0] ybase,
    output logic          ready,
    output logic          load,
    output logic          step,
    output logic          tile_mode,
    output logic          pix_valid,
    output logic [XW-1:0] pix_x,
    output logic [XW-1:0] pix_y
);
    sh_state_t     state_q, state_d;
    logic [CW-1:0] rem_q, rem_d;
    logic [XW-1:0] xc_q, xc_d;
    logic [XW-1:0] tc_q, tc_d;
    logic [2:0]    sub_q, sub_d;
    logic          go_span, go_tile;

    assign go_span = wr_en && (wr_sel == SEL_SPAN) && (wr_count != '0);
    assign go_tile = wr_en && (wr_sel == SEL_TILE) && (wr_count != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            xc_q    <= '0;
            tc_q    <= '0;
            sub_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            xc_q    <= xc_d;
            tc_q    <= tc_d;
            sub_q   <= sub_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        xc_d    = xc_q;
        tc_d    = tc_q;
        sub_d   = sub_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_span) begin
                    state_d = ST_SPAN;
                    rem_d   = wr_count;
                    xc_d    = xbase;
                end else if (go_tile) begin
                    state_d = ST_TILE;
                    rem_d   = wr_count;
                    tc_d    = xbase;
                    sub_d   = '0;
                end
            end
            ST_SPAN: begin
                rem_d = rem_q - 1'b1;
                xc_d  = xc_q + 1'b1;
                if (rem_q == CW'(1))
                    state_d = ST_IDLE;
            end
            ST_TILE: begin
                sub_d = sub_q + 1'b1;
                if (sub_q == 3'd7) begin
                    tc_d  = tc_q + 1'b1;
                    rem_d = rem_q - 1'b1;
                    if (rem_q == CW'(1))
                        state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready     = 1'b0;
        load      = 1'b0;
        step      = 1'b0;
        tile_mode = 1'b0;
        pix_valid = 1'b0;
        pix_x     = xc_q;
        pix_y     = ybase;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
                load  = go_span;
            end
            ST_SPAN: begin
                step      = 1'b1;
                pix_valid = 1'b1;
            end
            ST_TILE: begin
                tile_mode = 1'b1;
                pix_valid = 1'b1;
                pix_x     = {tc_q[XW-3:0], sub_q[1:0]};
                pix_y     = ybase + XW'(sub_q[2]);
            end
            default: ;
        endcase
    end

    // R7: a zero count leaves the unit ready
    assert_zero_count_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_en && (wr_sel == SEL_SPAN || wr_sel == SEL_TILE) && wr_count == '0)
        |=> ready);

    // R4: span x steps by one between neighbouring pixels
    assert_span_x_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPAN && $past(state_q) == ST_SPAN) |-> pix_x == $past(pix_x) + XW'(1));

    // R9: tile pixels stay on the two rows at base y
    assert_tile_rows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tile_mode |-> (pix_y == ybase || pix_y == ybase + XW'(1)));

    // R3: output only after a write starts a run
    assert_run_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_valid) |-> $past(wr_en));
endmodule

// File: rtl/span_shader.sv
module span_shader
    import span_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic        ready,
    output logic        pix_valid,
    output logic [15:0] pix_x,
    output logic [15:0] pix_y,
    output logic [7:0]  pix_r,
    output logic [7:0]  pix_g,
    output logic [7:0]  pix_b,
    output logic [15:0] pix_z
);
    localparam int DW   = 32;
    localparam int FRAC = 16;
    localparam int CW   = 16;
    localparam int XW   = 16;

    logic [NCH-1:0][DW-1:0] start_v, grad_v, acc;
    logic [NCH-1:0][DW-1:0] src;
    logic [XW-1:0]          xbase, ybase;
    logic                   load, step, tile_mode;

    span_regs #(.DW(DW), .XW(XW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .accept(ready),
        .start_v(start_v), .grad_v(grad_v), .xbase(xbase), .ybase(ybase)
    );

    span_lanes #(.DW(DW)) u_lanes (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .start_v(start_v), .grad_v(grad_v), .acc(acc)
    );

    span_ctrl #(.CW(CW), .XW(XW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_count(wr_data[CW-1:0]), .xbase(xbase), .ybase(ybase),
        .ready(ready), .load(load), .step(step), .tile_mode(tile_mode),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y)
    );

    assign src   = tile_mode ? start_v : acc;
    assign pix_r = clip8(signed'(src[0][DW-1:FRAC]));
    assign pix_g = clip8(signed'(src[1][DW-1:FRAC]));
    assign pix_b = clip8(signed'(src[2][DW-1:FRAC]));
    assign pix_z = src[3][DW-1:FRAC];

    // R9 / R10: colour and depth hold through a tile fill
    assert_tile_const_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_mode && $past(tile_mode)) |-> $stable({pix_r, pix_g, pix_b, pix_z}));
endmodule

// File: tb/tb_span_shader.sv
module tb_span_shader;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        ready, pix_valid;
    logic [15:0] pix_x, pix_y, pix_z;
    logic [7:0]  pix_r, pix_g, pix_b;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] m_start [4];
    logic [31:0] m_grad [4];
    logic [15:0] m_x, m_y;

    span_shader dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ready(ready), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_z(pix_z)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=%0d exp=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [7:0] e_clip(input logic [31:0] v);
        logic signed [15:0] s;
        s = signed'(v[31:16]);
        if (s < 0) return 8'd0;
        if (s > 16'sd255) return 8'd255;
        return v[23:16];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prog(input logic [31:0] s0, s1, s2, s3, g0, g1, g2, g3, input logic [15:0] x, y);
        m_start[0] = s0; m_start[1] = s1; m_start[2] = s2; m_start[3] = s3;
        m_grad[0] = g0; m_grad[1] = g1; m_grad[2] = g2; m_grad[3] = g3;
        m_x = x; m_y = y;
        for (int c = 0; c < 4; c++) wr(4'(c), m_start[c]);
        for (int c = 0; c < 4; c++) wr(4'(4 + c), m_grad[c]);
        wr(4'd8, {16'd0, x});
        wr(4'd9, {16'd0, y});
    endtask

    task automatic do_span(input int n, input bit poke);
        logic [31:0] a [4];
        wr(4'd10, n);
        for (int i = 0; i < n; i++) begin
            for (int c = 0; c < 4; c++) a[c] = m_start[c] + m_grad[c] * i;
            chk(pix_valid === 1'b1, "R3 valid", {31'd0, pix_valid}, 1);
            chk(ready === 1'b0, "R3 busy", {31'd0, ready}, 0);
            chk(pix_x === m_x + 16'(i), "R4 x", pix_x, m_x + 16'(i));
            chk(pix_y === m_y, "R4 y", pix_y, m_y);
            chk(pix_r === e_clip(a[0]), "R5/R6 r", pix_r, e_clip(a[0]));
            chk(pix_g === e_clip(a[1]), "R5/R6 g", pix_g, e_clip(a[1]));
            chk(pix_b === e_clip(a[2]), "R5/R6 b", pix_b, e_clip(a[2]));
            chk(pix_z === a[3][31:16], "R5 z", pix_z, a[3][31:16]);
            if (poke && i == 0) begin
                wr_en = 1'b1; wr_sel = 4'd0; wr_data = 32'h0042_0000;
            end else if (poke && i == 1) begin
                wr_en = 1'b1; wr_sel = 4'd8; wr_data = 32'h0000_0777;
            end else if (poke && i == 2) begin
                wr_en = 1'b1; wr_sel = 4'd10; wr_data = 32'd5;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk(ready === 1'b1, "R3 ready after run", {31'd0, ready}, 1);
        chk(pix_valid === 1'b0, "R3 end", {31'd0, pix_valid}, 0);
        @(negedge clk);
        chk(pix_valid === 1'b0, "R8 no extra run", {31'd0, pix_valid}, 0);
    endtask

    task automatic do_tile(input int m);
        logic [15:0] ex, ey;
        wr(4'd11, m);
        for (int k = 0; k < m; k++) begin
            for (int p = 0; p < 8; p++) begin
                ex = 16'((m_x + 16'(k)) * 4 + (p % 4));
                ey = m_y + 16'(p / 4);
                chk(pix_valid === 1'b1, "R9 valid", {31'd0, pix_valid}, 1);
                chk(pix_x === ex, "R9 x", pix_x, ex);
                chk(pix_y === ey, "R9 y", pix_y, ey);
                chk(pix_r === e_clip(m_start[0]), "R9 r", pix_r, e_clip(m_start[0]));
                chk(pix_g === e_clip(m_start[1]), "R9 g", pix_g, e_clip(m_start[1]));
                chk(pix_b === e_clip(m_start[2]), "R9 b", pix_b, e_clip(m_start[2]));
                chk(pix_z === m_start[3][31:16], "R9 z", pix_z, m_start[3][31:16]);
                @(negedge clk);
            end
        end
        chk(ready === 1'b1, "R9 ready after tiles", {31'd0, ready}, 1);
        chk(pix_valid === 1'b0, "R9 end", {31'd0, pix_valid}, 0);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk(ready === 1'b1, "R1 ready", {31'd0, ready}, 1);
        chk(pix_valid === 1'b0, "R1 valid", {31'd0, pix_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready === 1'b1, "R1 ready out of reset", {31'd0, ready}, 1);

        // R6 directed: negative, overflow, mid-range ramps crossing both limits
        prog(32'hFFFB_0000, 32'h012C_0000, 32'h00FE_8000, 32'h1234_0000,
             32'h0001_8000, 32'hFFFF_0000, 32'h0000_4000, 32'hFFFF_F000, 16'd100, 16'd7);
        do_span(12, 1'b0);

        // R8: writes during a span are dropped (start R, base x, count)
        do_span(6, 1'b1);

        // R7: zero counts
        wr(4'd10, 32'd0);
        chk(ready === 1'b1, "R7 span zero ready", {31'd0, ready}, 1);
        chk(pix_valid === 1'b0, "R7 span zero valid", {31'd0, pix_valid}, 0);
        wr(4'd11, 32'd0);
        chk(ready === 1'b1, "R7 tile zero ready", {31'd0, ready}, 1);
        chk(pix_valid === 1'b0, "R7 tile zero valid", {31'd0, pix_valid}, 0);

        // R9 then R10: tile fill, then a span from unchanged start values
        do_tile(3);
        do_span(4, 1'b0);

        // R11: repeated span restarts accumulators
        do_span(5, 1'b0);
        do_span(5, 1'b0);

        // R2/R5: random programs
        for (int t = 0; t < 20; t++) begin
            logic [31:0] g [4];
            for (int c = 0; c < 4; c++) begin
                g[c] = $urandom & 32'h0003_FFFF;
                if ($urandom_range(0, 1) == 1) g[c] = -g[c];
            end
            prog({16'($urandom_range(0, 300)), 16'($urandom)},
                 {16'($urandom_range(0, 300)), 16'($urandom)},
                 {16'($urandom_range(0, 300)), 16'($urandom)},
                 $urandom, g[0], g[1], g[2], g[3],
                 16'($urandom_range(0, 4000)), 16'($urandom_range(0, 4000)));
            if (t % 4 == 3)
                do_tile($urandom_range(1, 4));
            else
                do_span($urandom_range(1, 40), 1'b0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule